// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block derives the serial clock of an SPI master from a fast main clock. A first stage divides the main clock by a power of two, (2 << DIV) with a 2-bit DIV code. A second stage then divides that intermediate rate by 2·(BRG+1) with a 6-bit BRG code. The total ratio between the main clock and the serial clock is therefore (2 << DIV)·2·(BRG+1). Across the legal settings this gives rates from main/20 (DIV=0, BRG=4) down to main/2048 (DIV=3, BRG=63).

Besides the clock level, the block gives a shift engine two strobes, each one main-clock cycle wide. One marks every move of the serial clock away from its idle level (leading edge). The other marks every return to idle (trailing edge). The idle level is set by a polarity input.

Software writes the ratio codes and the polarity while the generator is disabled. The block captures them on every disabled cycle and holds them frozen while it runs. Each enable starts a fresh waveform from the idle level with both divider counters cleared.

Top module: `spiclk_gen`

## Requirements
- R1: While reset is asserted, and for the two cycles of synchronised release that follow, `sclk_o` is 0 and neither strobe is asserted.
- R2: While enabled, `sclk_o` changes level every H main-clock cycles, where H = (2 << DIV)·(BRG+1). The full serial clock period is 2·H.
- R3: With DIV=0 and BRG=4 the period is 20 main cycles. With DIV=3 and BRG=63 it is 2048 main cycles. No half period is shorter than 10 or longer than 1024 cycles.
- R4: A BRG code below 4 is used as 4, so BRG values 0 to 3 give the same timing as BRG=4.
- R5: On each clock edge where `en_i` is 0, `sclk_o` takes the value of `cpol_i` (1 = idle high, 0 = idle low) and both strobes are 0.
- R6: Changes to `div_i`, `brg_i` or `cpol_i` made while `en_i` is 1 have no effect on the running waveform. The codes are captured only on edges where `en_i` is 0.
- R7: After `en_i` rises, including after a disable in the middle of a half period, the first level change happens on exactly the H-th enabled edge, from the idle level.
- R8: `lead_o` is 1 for exactly the one cycle in which `sclk_o` has just left the idle level. `trail_o` is 1 for exactly the one cycle in which it has just returned to idle. Every level change while enabled carries exactly one of the two strobes, and the two strobes are never 1 together.
- R9: With polarity 1 the waveform is the inverse of the polarity-0 waveform, and `lead_o` then marks the falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run the generator; 0 holds the idle level and captures the codes |
| div_i | input | 2 | Power-of-two prescale code (divide by 2 << code) |
| brg_i | input | 6 | Linear divide code, BRG+1 prescaled ticks per half period |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on each departure from idle |
| trail_o | output | 1 | One-cycle strobe on each return to idle |

## Verification
The bench builds the generator with its default widths: a 2-bit prescale code, a 6-bit linear code, and a legal linear range of 4 to 63. This makes the slowest setting, a half period of 1024 cycles, short enough to observe over several full periods. Because 63 is the largest 6-bit value, only the lower clamp is built and exercised; the upper clamp branch drops out of the build. A behavioural model counts enabled edges and predicts the level and both strobes on every cycle. Measured lead-to-lead spacing confirms the period at both corners and at intermediate settings, under either polarity, for codes changed mid-run, and across a restart in the middle of a half period.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
  localparam int unsigned SPICLK_DIV_W   = 2;
  localparam int unsigned SPICLK_BRG_W   = 6;
  localparam int unsigned SPICLK_BRG_MIN = 4;
  localparam int unsigned SPICLK_BRG_MAX = 63;

  // Kind of level change produced by the half-period counter.
  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } edge_kind_e;
endpackage

// File: rtl/spiclk_cfg.sv
// Captures ratio codes and polarity on every disabled edge; clamps the linear code.
module spiclk_cfg #(
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned BRG_W   = 6,
  parameter int unsigned BRG_MIN = 4,
  parameter int unsigned BRG_MAX = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cpol_i,
  output logic [DIV_W-1:0] div_o,
  output logic [BRG_W-1:0] brg_o,
  output logic             cpol_o
);
  localparam logic [BRG_W-1:0] LO = BRG_W'(BRG_MIN);
  localparam logic [BRG_W-1:0] HI = BRG_W'(BRG_MAX);

  logic [BRG_W-1:0] brg_lo;
  logic [BRG_W-1:0] brg_clamped;

  assign brg_lo = (brg_i < LO) ? LO : brg_i;

  generate
    if (BRG_MAX < (2 ** BRG_W) - 1) begin : g_hi_clamp
      assign brg_clamped = (brg_lo > HI) ? HI : brg_lo;
    end else begin : g_no_hi_clamp
      assign brg_clamped = brg_lo;
    end
  endgenerate

  logic [DIV_W-1:0] div_d, div_q;
  logic [BRG_W-1:0] brg_d, brg_q;
  logic             cpol_d, cpol_q;

  always_comb begin
    div_d  = div_q;
    brg_d  = brg_q;
    cpol_d = cpol_q;
    if (load_i) begin
      div_d  = div_i;
      brg_d  = brg_clamped;
      cpol_d = cpol_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      brg_q  <= LO;
      cpol_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      brg_q  <= brg_d;
      cpol_q <= cpol_d;
    end
  end

  assign div_o  = div_q;
  assign brg_o  = brg_q;
  assign cpol_o = cpol_q;
endmodule

// File: rtl/spiclk_prescale.sv
// Power-of-two stage: one tick every (2 << div) enabled cycles.
module spiclk_prescale #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = 1 << DIV_W;

  logic [PRE_W-1:0] cnt_d, cnt_q;
  logic [PRE_W-1:0] last;

  always_comb begin
    last = {PRE_W{1'b1}} >> (PRE_W - 1 - int'(div_i));
  end

  assign tick_o = run_i && (cnt_q == last);

  always_comb begin
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spiclk_halfcnt.sv
// Linear stage: toggles the serial clock after brg+1 ticks and classifies the edge.
module spiclk_halfcnt
  import spiclk_pkg::*;
#(
  parameter int unsigned BRG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             idle_lvl_i,
  input  logic             pol_run_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [BRG_W-1:0] lin_d, lin_q;
  logic             sclk_d, sclk_q;
  edge_kind_e       kind_d, kind_q;
  logic             boundary;

  assign boundary = tick_i && (lin_q == brg_i);

  always_comb begin
    lin_d  = lin_q;
    sclk_d = sclk_q;
    kind_d = EDGE_NONE;
    if (!run_i) begin
      lin_d  = '0;
      sclk_d = idle_lvl_i;
    end else if (tick_i) begin
      if (boundary) begin
        lin_d  = '0;
        sclk_d = ~sclk_q;
        kind_d = (sclk_q == pol_run_i) ? EDGE_LEAD : EDGE_TRAIL;
      end else begin
        lin_d = lin_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q  <= '0;
      sclk_q <= 1'b0;
      kind_q <= EDGE_NONE;
    end else begin
      lin_q  <= lin_d;
      sclk_q <= sclk_d;
      kind_q <= kind_d;
    end
  end

  assign sclk_o  = sclk_q;
  assign lead_o  = (kind_q == EDGE_LEAD);
  assign trail_o = (kind_q == EDGE_TRAIL);
endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
  import spiclk_pkg::*;
#(
  parameter int unsigned DIV_W   = SPICLK_DIV_W,
  parameter int unsigned BRG_W   = SPICLK_BRG_W,
  parameter int unsigned BRG_MIN = SPICLK_BRG_MIN,
  parameter int unsigned BRG_MAX = SPICLK_BRG_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cpol_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  // Asynchronous assert, synchronous release.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [DIV_W-1:0] div_run;
  logic [BRG_W-1:0] brg_run;
  logic             pol_run;
  logic             tick;

  spiclk_cfg #(
    .DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN), .BRG_MAX(BRG_MAX)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (!en_i),
    .div_i  (div_i),
    .brg_i  (brg_i),
    .cpol_i (cpol_i),
    .div_o  (div_run),
    .brg_o  (brg_run),
    .cpol_o (pol_run)
  );

  spiclk_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (en_i),
    .div_i  (div_run),
    .tick_o (tick)
  );

  spiclk_halfcnt #(.BRG_W(BRG_W)) u_half (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run_i      (en_i),
    .tick_i     (tick),
    .brg_i      (brg_run),
    .idle_lvl_i (cpol_i),
    .pol_run_i  (pol_run),
    .sclk_o     (sclk_o),
    .lead_o     (lead_o),
    .trail_o    (trail_o)
  );
endmodule

// File: rtl/spiclk_chk.sv
module spiclk_chk #(
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned BRG_MIN = 4,
  parameter int unsigned BRG_MAX = 63
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o
);
  localparam int unsigned MIN_HALF = 2 * (BRG_MIN + 1);
  localparam int unsigned MAX_HALF = (2 << ((1 << DIV_W) - 1)) * (BRG_MAX + 1);
  localparam int unsigned GAP_W    = $clog2(MAX_HALF + 2) + 1;

  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (!en_i)            gap_q <= '0;
    else if (lead_o || trail_o) gap_q <= GAP_W'(1);
    else if (gap_q != '1)      gap_q <= gap_q + 1'b1;
  end

  AST_IDLE_FOLLOWS_POL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_i) |-> (sclk_o == $past(cpol_i)) && !lead_o && !trail_o); // R5
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_o && trail_o)); // R8
  AST_STROBE_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_o || trail_o) |-> (sclk_o != $past(sclk_o))); // R8
  AST_CHANGE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && (sclk_o != $past(sclk_o))) |-> (lead_o || trail_o)); // R8
  AST_HALF_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_o || trail_o) |-> (gap_q >= GAP_W'(MIN_HALF))); // R3
  AST_HALF_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GAP_W'(MAX_HALF)); // R3
endmodule

bind spiclk_gen spiclk_chk #(
  .DIV_W(DIV_W), .BRG_MIN(BRG_MIN), .BRG_MAX(BRG_MAX)
) u_spiclk_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .en_i    (en_i),
  .cpol_i  (cpol_i),
  .sclk_o  (sclk_o),
  .lead_o  (lead_o),
  .trail_o (trail_o)
);

// File: tb/test_spiclk_gen.sv
`timescale 1ns/1ps
module test_spiclk_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_i;
  logic [1:0] div_i;
  logic [5:0] brg_i;
  logic       cpol_i;
  logic       sclk_o, lead_o, trail_o;

  always #10 clk = ~clk;

  spiclk_gen i_spiclk_gen (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .div_i(div_i), .brg_i(brg_i),
    .cpol_i(cpol_i), .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  string tag    = "R1";

  // Behavioural model state
  int m_n, m_div, m_brg, m_h;
  bit m_pol, m_sclk, m_lead, m_trail;
  int cyc = 0;
  int last_lead = -1;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_n = 0; m_div = 0; m_brg = 4; m_pol = 0; m_sclk = 0; m_lead = 0; m_trail = 0;
    end else if (!en_i) begin
      m_div = div_i; m_brg = (brg_i < 4) ? 4 : brg_i; m_pol = cpol_i;
      m_sclk = cpol_i; m_n = 0; m_lead = 0; m_trail = 0;
    end else begin
      m_n++;
      m_h = (2 << m_div) * (m_brg + 1);
      m_lead = 0; m_trail = 0;
      if (m_n % m_h == 0) begin
        m_sclk = ~m_sclk;
        if (m_sclk != m_pol) m_lead = 1; else m_trail = 1;
      end
    end
  end

  // Compare every cycle, away from the edge
  always @(posedge clk) begin
    #1;
    check(tag, sclk_o, m_sclk, "sclk level");
    check("R8", lead_o, m_lead, "lead strobe");
    check("R8", trail_o, m_trail, "trail strobe");
    if (!en_i) last_lead = -1;
    else if (lead_o) begin
      if (last_lead >= 0)
        check(tag, cyc - last_lead, 2 * (2 << m_div) * (m_brg + 1), "period");
      last_lead = cyc;
    end
  end

  task automatic run(input int d, input int b, input bit p, input int n, input string req);
    @(negedge clk);
    en_i = 0; div_i = 2'(d); brg_i = 6'(b); cpol_i = p; tag = req;
    repeat (2) @(negedge clk);
    check("R5", sclk_o, p, "idle level while disabled");
    en_i = 1;
    repeat (n) @(negedge clk);
    en_i = 0;
    repeat (2) @(negedge clk);
  endtask

  // Measures periods between leads for one setting
  task automatic measure(input int d, input int b, input int exp_period, input string req);
    int first, second;
    @(negedge clk);
    en_i = 0; div_i = 2'(d); brg_i = 6'(b); cpol_i = 0; tag = req;
    repeat (2) @(negedge clk);
    en_i = 1;
    first = -1; second = -1;
    while (second < 0) begin
      @(posedge clk); #2;
      if (lead_o) begin
        if (first < 0) first = cyc; else second = cyc;
      end
    end
    check(req, second - first, exp_period, "measured period");
    @(negedge clk);
    en_i = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; en_i = 0; div_i = 0; brg_i = 4; cpol_i = 0;
    repeat (5) @(negedge clk);
    check("R1", sclk_o, 0, "reset level");
    check("R1", lead_o | trail_o, 0, "reset strobes");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", sclk_o, 0, "after release");

    measure(0, 4, 20, "R3");
    measure(3, 63, 2048, "R3");
    measure(1, 10, 88, "R2");
    measure(2, 7, 128, "R2");
    measure(0, 0, 20, "R4");
    measure(1, 3, 40, "R4");

    run(0, 4, 0, 120, "R2");
    run(1, 10, 0, 400, "R2");
    run(2, 7, 1, 600, "R9");
    run(0, 2, 1, 150, "R4");
    run(3, 63, 0, 4200, "R3");

    // R6: change codes while running; waveform must not change
    @(negedge clk);
    en_i = 0; div_i = 0; brg_i = 5; cpol_i = 0; tag = "R6";
    repeat (2) @(negedge clk);
    en_i = 1;
    repeat (30) @(negedge clk);
    div_i = 3; brg_i = 40; cpol_i = 1;
    repeat (300) @(negedge clk);
    en_i = 0;
    repeat (2) @(negedge clk);
    check("R6", sclk_o, 1, "new polarity taken once disabled");

    // R7: disable mid half period, restart from idle with cleared counters
    @(negedge clk);
    div_i = 1; brg_i = 9; cpol_i = 0; tag = "R7";
    repeat (2) @(negedge clk);
    en_i = 1;
    repeat (55) @(negedge clk);
    en_i = 0;
    @(negedge clk);
    en_i = 1;
    repeat (39) @(negedge clk);
    check("R7", sclk_o, 0, "no change before H edges");
    @(negedge clk);
    check("R7", sclk_o, 1, "first change on H-th edge");
    check("R7", lead_o, 1, "lead on first change");
    repeat (200) @(negedge clk);
    en_i = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule